// File: doc/BRIEF.md
# Byte-Framed Serial Register Port

This block is a host-driven serial slave that gives a controller access to a bank of byte-wide registers over four wires: a serial clock, an active-low select, a data input and a data output whose driver can be released. All four pins are asynchronous to the block, which samples them with a faster system clock. The serial clock passes through a stability filter so that short spikes never count as edges. Incoming data is captured on accepted falling edges of the serial clock. Outgoing data changes on accepted rising edges.

Each access is two bytes long, sent most significant bit first. The first byte is a header: its top bit selects the direction (1 = read, 0 = write) and its lower seven bits give the register address. For a write, the second byte is the value to store, and a one-cycle write strobe goes to the register bank only after that byte is complete. For a read, a one-cycle read strobe goes out once the header is complete. The returned value is then shifted out during the second byte, with the output driver enabled only for that byte. Releasing the select at any moment returns the port to idle and discards whatever was partly received.

Top module: `ser_reg_port`

## Requirements
- R1: After reset the output enable, write strobe and read strobe are low and the data output is 1.
- R2: While the select is high, the output enable stays low and serial clock activity causes no strobe.
- R3: The first byte is taken MSB first: bit 7 is the direction (1 = read, 0 = write) and bits 6..0 are the address presented on the address output.
- R4: For a write, exactly one single-cycle write strobe carries the address and the second byte (MSB first) once its eighth bit is sampled.
- R5: Raising the select before the second byte is complete produces no write strobe, and the next access decodes from a fresh header.
- R6: For a read, exactly one single-cycle read strobe is issued after the header. The returned byte appears on the data output MSB first, and each bit is updated on an accepted rising serial clock edge.
- R7: The output enable is high only during the second byte of a read while the select is low.
- R8: A serial clock pulse that lasts fewer than FILT_CYC system clock cycles is ignored.
- R9: Serial clock edges after the second byte, before the select is raised, cause no further strobe.
- R10: Data input bits are sampled on the accepted falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| sel_n_i | input | 1 | Active-low access select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Drive enable for the serial data output |
| reg_addr_o | output | 7 | Register address taken from the header |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data from the register bank, valid while the read strobe is high |

## Verification
Random addresses and data go through full write accesses and are then read back. This shows whether header decoding, bit order and the register handshake agree in both directions. Directed frames cover the other cases. Clocking with the select high separates the idle hold from normal decoding. A select released mid-frame shows whether partial data can be committed. Trailing clocks after the data byte show whether a second strobe can occur. Spikes of one cycle and of FILT_CYC-1 cycles, inserted inside a frame, show whether the filter lets a false edge shift the bit count.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int BIT_CW      = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_DONE
    } port_state_t;

    typedef struct packed {
        logic              is_rd;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    function automatic hdr_t hdr_decode(input logic [DATA_W-1:0] b);
        hdr_t h;
        h.is_rd = b[DATA_W-1];
        h.addr  = b[ADDR_W-1:0];
        return h;
    endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= RST_VAL;
                else if (s == 0)
                    stg[s] <= d_i;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ser_glitch_filt.sv
module ser_glitch_filt #(
    parameter int STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic          lvl_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            run_q  <= '0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (raw_i == lvl_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                lvl_q  <= raw_i;
                run_q  <= '0;
                rise_o <= raw_i;
                fall_o <= !raw_i;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ser_frame_ctl.sv
module ser_frame_ctl
    import ser_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_act,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rd_o,
    output logic              sdo_o,
    output logic              oe_o
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DATA_W - 1);

    port_state_t       st_q;
    hdr_t              hdr_q;
    logic [BIT_CW-1:0] bit_q;
    logic [DATA_W-2:0] in_sr_q;
    logic [DATA_W-1:0] out_sr_q;
    logic [DATA_W-1:0] in_byte;

    assign in_byte = {in_sr_q, din_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            hdr_q    <= '0;
            bit_q    <= '0;
            in_sr_q  <= '0;
            out_sr_q <= '0;
            wr_o     <= 1'b0;
            wdata_o  <= '0;
            rd_o     <= 1'b0;
            sdo_o    <= 1'b1;
        end else begin
            wr_o <= 1'b0;
            rd_o <= 1'b0;
            if (rd_o)
                out_sr_q <= rdata_i;
            if (!en_act) begin
                st_q  <= ST_IDLE;
                bit_q <= '0;
                sdo_o <= 1'b1;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        st_q  <= ST_HDR;
                        bit_q <= '0;
                    end
                    ST_HDR: if (fall_i) begin
                        in_sr_q <= in_byte[DATA_W-2:0];
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == LAST_BIT) begin
                            hdr_q <= hdr_decode(in_byte);
                            rd_o  <= in_byte[DATA_W-1];
                            st_q  <= ST_BODY;
                        end
                    end
                    ST_BODY: begin
                        if (rise_i && hdr_q.is_rd) begin
                            sdo_o    <= out_sr_q[DATA_W-1];
                            out_sr_q <= {out_sr_q[DATA_W-2:0], 1'b0};
                        end
                        if (fall_i) begin
                            in_sr_q <= in_byte[DATA_W-2:0];
                            bit_q   <= bit_q + 1'b1;
                            if (bit_q == LAST_BIT) begin
                                st_q <= ST_DONE;
                                if (!hdr_q.is_rd) begin
                                    wr_o    <= 1'b1;
                                    wdata_o <= in_byte;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign addr_o = hdr_q.addr;
    assign oe_o   = en_act && (st_q == ST_BODY) && hdr_q.is_rd;
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_port_pkg::*;
#(
    parameter int FILT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sel_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    logic [1:0] ctl_s;
    logic       sclk_s;
    logic       sclk_rise;
    logic       sclk_fall;
    logic       en_act;

    ser_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) i_ctl_sync (
        .clk(clk), .rst(rst), .d_i({sel_n_i, sdi_i}), .q_o(ctl_s)
    );

    ser_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_clk_sync (
        .clk(clk), .rst(rst), .d_i(sclk_i), .q_o(sclk_s)
    );

    ser_glitch_filt #(.STABLE_CYC(FILT_CYC)) i_filt (
        .clk(clk), .rst(rst), .raw_i(sclk_s),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    assign en_act = !ctl_s[1];

    ser_frame_ctl i_ctl (
        .clk(clk), .rst(rst), .en_act(en_act),
        .rise_i(sclk_rise), .fall_i(sclk_fall), .din_i(ctl_s[0]),
        .rdata_i(reg_rdata_i), .addr_o(reg_addr_o),
        .wr_o(reg_wr_o), .wdata_o(reg_wdata_o), .rd_o(reg_rd_o),
        .sdo_o(sdo_o), .oe_o(sdo_oe_o)
    );
endmodule

// File: rtl/ser_reg_port_chk.sv
module ser_reg_port_chk (
    input logic clk,
    input logic rst,
    input logic en_act,
    input logic sclk_rise,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic reg_wr_o,
    input logic reg_rd_o
);
    // R4: write strobe lasts one cycle
    a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> !reg_wr_o);

    // R6: read strobe lasts one cycle
    a_r6_rd_single: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |=> !reg_rd_o);

    // R2: driver released while deselected
    a_r2_idle_no_oe: assert property (@(posedge clk) disable iff (rst)
        !en_act |-> !sdo_oe_o);

    // R5: a write commits only while selected
    a_r5_wr_selected: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> $past(en_act));

    // R7: no write during a read body
    a_r7_oe_not_write: assert property (@(posedge clk) disable iff (rst)
        sdo_oe_o |-> !reg_wr_o);

    // R6: output bit moves only on an accepted rising edge
    a_r6_sdo_on_rise: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe_o && !sclk_rise) |=> (!sdo_oe_o || $stable(sdo_o)));

    // R4, R6: strobes never coincide
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_o && reg_rd_o));
endmodule

bind ser_reg_port ser_reg_port_chk i_chk (
    .clk(clk), .rst(rst), .en_act(en_act), .sclk_rise(sclk_rise),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o)
);

// File: tb/test_ser_reg_port.sv
`timescale 1ns/1ps
module test_ser_reg_port;
    localparam int FILT = 8;
    localparam int HP   = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
    logic       sdo, sdo_oe, reg_wr, reg_rd;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] bank [128];
    logic [7:0] exp_bank [128];
    int wr_cnt = 0, rd_cnt = 0;
    logic [6:0] last_waddr, last_raddr;
    logic [7:0] last_wdata;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ser_reg_port #(.FILT_CYC(FILT)) i_ser_reg_port (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(reg_addr),
        .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
            wr_cnt     <= wr_cnt + 1;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt     <= rd_cnt + 1;
            last_raddr <= reg_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access: nbits clocks of word w (MSB first), optional abort and spike
    task automatic xfer(input logic [15:0] w, input int nbits, input int abort_at,
                        input int spike_at, input int spike_w, input bit sel,
                        output logic [7:0] rbits, output bit oe_ok);
        bit is_rd = w[15];
        @(negedge clk) sel_n = !sel;
        repeat (10) @(negedge clk);
        rbits = '0;
        oe_ok = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            if (i == abort_at) break;
            sdi  = (i < 16) ? w[15-i] : 1'b0;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            if (i >= 8 && i < 16) rbits = {rbits[6:0], sdo};
            if (sdo_oe !== (sel && is_rd && i >= 8 && i < 16)) oe_ok = 1'b0;
            sclk = 1'b0;
            repeat (HP) @(negedge clk);
            if (i == spike_at) begin
                sclk = 1'b1;
                repeat (spike_w) @(negedge clk);
                sclk = 1'b0;
                repeat (HP) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        sel_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
        logic [7:0] rb; bit ok; int c0 = wr_cnt;
        xfer({1'b0, a, d}, 16, -1, -1, 0, 1'b1, rb, ok);
        exp_bank[a] = d;
        chk(wr_cnt == c0 + 1, req, wr_cnt - c0, 1);
        chk(last_waddr == a && last_wdata == d, req, {last_waddr, last_wdata}, {a, d});
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        logic [7:0] rb; bit ok; int c0 = rd_cnt;
        xfer({1'b1, a, 8'h00}, 16, -1, -1, 0, 1'b1, rb, ok);
        chk(rd_cnt == c0 + 1 && last_raddr == a, req, last_raddr, a);
        chk(rb == exp_bank[a], req, rb, exp_bank[a]);
        chk(ok, {req, " R7 oe window"}, ok, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb; bit ok; int c0; int unsigned s;
        for (int i = 0; i < 128; i++) begin
            bank[i] = 8'(i * 3 + 1);
            exp_bank[i] = 8'(i * 3 + 1);
        end
        s = $urandom(32'h1C3A);
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R1 strobes", {reg_wr, reg_rd}, 0);
        chk(sdo == 1'b1, "R1 sdo", sdo, 1);

        // R2 clocking while deselected
        c0 = wr_cnt;
        xfer({1'b0, 7'h11, 8'hA5}, 16, -1, -1, 0, 1'b0, rb, ok);
        chk(wr_cnt == c0 && rd_cnt == 0, "R2 no strobe", wr_cnt - c0, 0);
        chk(ok, "R2 oe low", ok, 1);
        do_read(7'h11, "R2 R6 bank untouched");

        // directed corner values, R3 R4 R6 R10
        do_write(7'h00, 8'h80, "R4 R10 low addr");
        do_write(7'h7F, 8'h01, "R3 R4 top addr");
        do_read(7'h7F, "R3 R6 read top");
        do_read(7'h00, "R6 read low");

        // random writes then read back (R3 R4 R6 R10)
        for (int k = 0; k < 14; k++) begin
            logic [6:0] a = 7'($urandom);
            logic [7:0] d = 8'($urandom);
            do_write(a, d, "R4 random write");
            do_read(a, "R6 random read");
        end

        // R5 abort mid data byte, then fresh frame
        c0 = wr_cnt;
        xfer({1'b0, 7'h22, 8'h3C}, 16, 12, -1, 0, 1'b1, rb, ok);
        chk(wr_cnt == c0, "R5 abort no write", wr_cnt - c0, 0);
        do_read(7'h22, "R5 bank untouched");
        c0 = wr_cnt;
        xfer({1'b0, 7'h22, 8'h3C}, 16, 3, -1, 0, 1'b1, rb, ok);
        chk(wr_cnt == c0, "R5 abort in header", wr_cnt - c0, 0);
        do_write(7'h22, 8'hC3, "R5 fresh header");

        // R9 trailing clocks after the data byte
        c0 = wr_cnt;
        xfer({1'b0, 7'h33, 8'h5A}, 24, -1, -1, 0, 1'b1, rb, ok);
        exp_bank[7'h33] = 8'h5A;
        chk(wr_cnt == c0 + 1, "R9 single write", wr_cnt - c0, 1);
        chk(last_wdata == 8'h5A, "R9 data", last_wdata, 8'h5A);
        c0 = rd_cnt;
        xfer({1'b1, 7'h33, 8'h00}, 24, -1, -1, 0, 1'b1, rb, ok);
        chk(rd_cnt == c0 + 1 && rb == 8'h5A, "R9 single read", rb, 8'h5A);

        // R8 spikes inside header and data
        c0 = wr_cnt;
        xfer({1'b0, 7'h44, 8'h96}, 16, -1, 2, 1, 1'b1, rb, ok);
        exp_bank[7'h44] = 8'h96;
        chk(wr_cnt == c0 + 1 && last_waddr == 7'h44, "R8 1-cycle spike", last_waddr, 7'h44);
        c0 = wr_cnt;
        xfer({1'b0, 7'h45, 8'h69}, 16, -1, 10, FILT - 1, 1'b1, rb, ok);
        exp_bank[7'h45] = 8'h69;
        chk(wr_cnt == c0 + 1 && last_wdata == 8'h69, "R8 near-width spike", last_wdata, 8'h69);
        do_read(7'h44, "R8 readback a");
        do_read(7'h45, "R8 readback b");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule